// File: doc/BRIEF.md
# Memory Protection Region Checker

This block sits between a processor core and its memory ports. It checks every instruction fetch and every data load or store against two small tables of programmable address windows, one for fetches and one for data. Each window has an inclusive lower and upper address bound and a set of six permission bits. The permissions give read, write and execute rights separately for user mode and for supervisor mode. While the block is enabled, an access is granted only when the first window that covers its address grants the right that the access needs in the current mode.

A refused access never reaches memory. Its grant is held low in the same cycle that the request is presented, and a fault flag is raised. In the next cycle the block issues a registered exception request carrying a cause code and the faulting address, so that the core can take a precise exception on that access. System software loads the tables through a single-cycle register write port. When the block is disabled, every request is granted as presented.

Top module: `mprot_guard`

## Requirements
- R1: After reset every window in both tables is empty (upper bound below lower bound), all permission bits are clear and `exc_valid` is 0. As a result, any access made with the block enabled faults.
- R2: While `enable` is 0, `if_grant` equals `if_req`, `d_grant` equals `d_req`, and neither fault flag is raised.
- R3: A window covers an address when lower bound <= address <= upper bound. Both ends are included.
- R4: When several windows of a table cover an address, only the window with the lowest index decides the outcome.
- R5: An enabled access whose address no window of its table covers is refused.
- R6: A fetch checks only the fetch table and needs the execute bit of the current mode. Permission bits are: bit0 user read, bit1 user write, bit2 user execute, bit3 supervisor read, bit4 supervisor write, bit5 supervisor execute. `priv_super`=1 selects supervisor mode.
- R7: A data access checks only the data table. It needs the read bit of the current mode when `d_we`=0 and the write bit when `d_we`=1.
- R8: On each port, grant and fault are decided combinationally in the request cycle, are never both 1, and are both 0 without a request.
- R9: One cycle after a fault, `exc_valid` is 1 and `exc_cause` holds 1 for a fetch execute fault, 2 for a data read fault or 3 for a data write fault. `exc_addr` holds the faulting address. In a cycle after no fault, `exc_valid` is 0 and `exc_cause` is 0.
- R10: When the fetch port and the data port both fault in the same cycle, the fetch fault is reported.
- R11: A table write with `cfg_we`=1 selects the table with `cfg_side` (0 fetch, 1 data), the window with `cfg_idx`, and the field with `cfg_field` (0 lower bound, 1 upper bound, 2 permissions in `cfg_wdata[5:0]`; 3 has no effect). The write takes effect from the next cycle and leaves all other fields unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Protection enable |
| priv_super | input | 1 | 1 = supervisor mode, 0 = user mode |
| cfg_we | input | 1 | Table write strobe |
| cfg_side | input | 1 | Table select: 0 fetch, 1 data |
| cfg_idx | input | 3 | Window index |
| cfg_field | input | 2 | Field select |
| cfg_wdata | input | 32 | Write data |
| if_req | input | 1 | Fetch request |
| if_addr | input | 32 | Fetch address |
| if_grant | output | 1 | Fetch forwarded to memory |
| if_fault | output | 1 | Fetch refused |
| d_req | input | 1 | Data request |
| d_we | input | 1 | 1 = store, 0 = load |
| d_addr | input | 32 | Data address |
| d_grant | output | 1 | Data access forwarded to memory |
| d_fault | output | 1 | Data access refused |
| exc_valid | output | 1 | Exception request |
| exc_cause | output | 2 | Exception cause code |
| exc_addr | output | 32 | Faulting address |

## Verification
On every cycle, the assertions check that grant and fault exclude each other, that both stay low without a request, and that a disabled block passes requests straight through. They also check that the exception register follows the fault flags one cycle later with the right cause, including the rule that a fetch fault wins over a data fault. The decisions that depend on table contents can only be shown by the bench's scenarios, because they need a reference table. These cover inclusive bound edges, the lowest-index rule for overlapping windows, misses, per-mode rights and the separation of the two tables.

// File: rtl/mprot_pkg.sv
package mprot_pkg;

  typedef enum logic [1:0] {
    CAUSE_NONE  = 2'd0,
    CAUSE_EXEC  = 2'd1,
    CAUSE_READ  = 2'd2,
    CAUSE_WRITE = 2'd3
  } cause_e;

  typedef enum logic [1:0] {
    FLD_LO   = 2'd0,
    FLD_HI   = 2'd1,
    FLD_PERM = 2'd2,
    FLD_NONE = 2'd3
  } field_e;

  typedef enum logic [1:0] {
    KIND_READ  = 2'd0,
    KIND_WRITE = 2'd1,
    KIND_EXEC  = 2'd2
  } kind_e;

  localparam int PERM_W   = 6;
  localparam int SUP_BASE = 3;

  // bit position of the right needed by an access kind in a given mode
  function automatic int perm_bit(input logic sup, input kind_e kind);
    return (sup ? SUP_BASE : 0) + int'(kind);
  endfunction

endpackage

// File: rtl/mprot_region_table.sv
module mprot_region_table
  import mprot_pkg::*;
#(
  parameter int NREG = 8,
  parameter int AW   = 32,
  parameter int DW   = 32,
  localparam int IW  = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [IW-1:0]         wr_idx,
  input  logic [1:0]            wr_field,
  input  logic [DW-1:0]         wr_data,
  output logic [NREG-1:0][AW-1:0]     lo_q,
  output logic [NREG-1:0][AW-1:0]     hi_q,
  output logic [NREG-1:0][PERM_W-1:0] perm_q
);

  for (genvar r = 0; r < NREG; r++) begin : g_reg
    logic sel;
    assign sel = wr_en && (wr_idx == IW'(r));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lo_q[r]   <= '1;
        hi_q[r]   <= '0;
        perm_q[r] <= '0;
      end else if (sel) begin
        case (field_e'(wr_field))
          FLD_LO:   lo_q[r]   <= AW'(wr_data);
          FLD_HI:   hi_q[r]   <= AW'(wr_data);
          FLD_PERM: perm_q[r] <= wr_data[PERM_W-1:0];
          default:  ;
        endcase
      end
    end
  end

endmodule

// File: rtl/mprot_match.sv
module mprot_match
  import mprot_pkg::*;
#(
  parameter int NREG = 8,
  parameter int AW   = 32,
  localparam int IW  = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic [NREG-1:0][AW-1:0]     lo_q,
  input  logic [NREG-1:0][AW-1:0]     hi_q,
  input  logic [NREG-1:0][PERM_W-1:0] perm_q,
  input  logic [AW-1:0]               addr,
  output logic                        hit,
  output logic [IW-1:0]               hit_idx,
  output logic [PERM_W-1:0]           hit_perm
);

  function automatic logic covers(input logic [AW-1:0] lo,
                                  input logic [AW-1:0] hi,
                                  input logic [AW-1:0] a);
    return (a >= lo) && (a <= hi);
  endfunction

  logic [NREG-1:0] cover_vec;

  for (genvar r = 0; r < NREG; r++) begin : g_cov
    assign cover_vec[r] = covers(lo_q[r], hi_q[r], addr);
  end

  // walk from the top so the lowest covering index is the last to assign
  always_comb begin
    hit      = 1'b0;
    hit_idx  = '0;
    hit_perm = '0;
    for (int r = NREG - 1; r >= 0; r--) begin
      if (cover_vec[r]) begin
        hit      = 1'b1;
        hit_idx  = IW'(r);
        hit_perm = perm_q[r];
      end
    end
  end

endmodule

// File: rtl/mprot_port_check.sv
module mprot_port_check
  import mprot_pkg::*;
#(
  parameter int NREG = 8,
  parameter int AW   = 32,
  parameter bit IS_FETCH = 1'b1,
  localparam int IW  = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic                        enable,
  input  logic                        priv_super,
  input  logic                        req,
  input  logic                        we,
  input  logic [AW-1:0]               addr,
  input  logic [NREG-1:0][AW-1:0]     lo_q,
  input  logic [NREG-1:0][AW-1:0]     hi_q,
  input  logic [NREG-1:0][PERM_W-1:0] perm_q,
  output logic                        hit,
  output logic [IW-1:0]               hit_idx,
  output logic                        allowed,
  output logic                        grant,
  output logic                        fault
);

  logic [PERM_W-1:0] hit_perm;
  kind_e             kind;

  mprot_match #(.NREG(NREG), .AW(AW)) u_match (
    .lo_q    (lo_q),
    .hi_q    (hi_q),
    .perm_q  (perm_q),
    .addr    (addr),
    .hit     (hit),
    .hit_idx (hit_idx),
    .hit_perm(hit_perm)
  );

  if (IS_FETCH) begin : g_fetch
    assign kind = KIND_EXEC;
  end else begin : g_data
    assign kind = we ? KIND_WRITE : KIND_READ;
  end

  assign allowed = hit && hit_perm[perm_bit(priv_super, kind)];
  assign grant   = req && (!enable || allowed);
  assign fault   = req && enable && !allowed;

endmodule

// File: rtl/mprot_guard.sv
module mprot_guard
  import mprot_pkg::*;
#(
  parameter int NREG = 8,
  parameter int AW   = 32,
  parameter int DW   = 32,
  localparam int IW  = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic          priv_super,
  input  logic          cfg_we,
  input  logic          cfg_side,
  input  logic [IW-1:0] cfg_idx,
  input  logic [1:0]    cfg_field,
  input  logic [DW-1:0] cfg_wdata,
  input  logic          if_req,
  input  logic [AW-1:0] if_addr,
  output logic          if_grant,
  output logic          if_fault,
  input  logic          d_req,
  input  logic          d_we,
  input  logic [AW-1:0] d_addr,
  output logic          d_grant,
  output logic          d_fault,
  output logic          exc_valid,
  output logic [1:0]    exc_cause,
  output logic [AW-1:0] exc_addr
);

  localparam int NSIDE = 2;

  logic [NSIDE-1:0][NREG-1:0][AW-1:0]     lo_q;
  logic [NSIDE-1:0][NREG-1:0][AW-1:0]     hi_q;
  logic [NSIDE-1:0][NREG-1:0][PERM_W-1:0] perm_q;

  for (genvar s = 0; s < NSIDE; s++) begin : g_tab
    logic side_we;
    assign side_we = cfg_we && (cfg_side == 1'(s));

    mprot_region_table #(.NREG(NREG), .AW(AW), .DW(DW)) u_tab (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (side_we),
      .wr_idx  (cfg_idx),
      .wr_field(cfg_field),
      .wr_data (cfg_wdata),
      .lo_q    (lo_q[s]),
      .hi_q    (hi_q[s]),
      .perm_q  (perm_q[s])
    );
  end

  // named internal events for the checker
  logic          if_hit, d_hit, if_allowed, d_allowed;
  logic [IW-1:0] if_hit_idx, d_hit_idx;
  logic          any_fault;

  mprot_port_check #(.NREG(NREG), .AW(AW), .IS_FETCH(1'b1)) u_fetch (
    .enable    (enable),
    .priv_super(priv_super),
    .req       (if_req),
    .we        (1'b0),
    .addr      (if_addr),
    .lo_q      (lo_q[0]),
    .hi_q      (hi_q[0]),
    .perm_q    (perm_q[0]),
    .hit       (if_hit),
    .hit_idx   (if_hit_idx),
    .allowed   (if_allowed),
    .grant     (if_grant),
    .fault     (if_fault)
  );

  mprot_port_check #(.NREG(NREG), .AW(AW), .IS_FETCH(1'b0)) u_data (
    .enable    (enable),
    .priv_super(priv_super),
    .req       (d_req),
    .we        (d_we),
    .addr      (d_addr),
    .lo_q      (lo_q[1]),
    .hi_q      (hi_q[1]),
    .perm_q    (perm_q[1]),
    .hit       (d_hit),
    .hit_idx   (d_hit_idx),
    .allowed   (d_allowed),
    .grant     (d_grant),
    .fault     (d_fault)
  );

  assign any_fault = if_fault || d_fault;

  // exception request: fetch fault takes precedence over data fault
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exc_valid <= 1'b0;
      exc_cause <= CAUSE_NONE;
      exc_addr  <= '0;
    end else begin
      exc_valid <= any_fault;
      if (if_fault) begin
        exc_cause <= CAUSE_EXEC;
        exc_addr  <= if_addr;
      end else if (d_fault) begin
        exc_cause <= d_we ? CAUSE_WRITE : CAUSE_READ;
        exc_addr  <= d_addr;
      end else begin
        exc_cause <= CAUSE_NONE;
      end
    end
  end

endmodule

// File: rtl/mprot_guard_chk.sv
module mprot_guard_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        enable,
  input logic        if_req,
  input logic        if_grant,
  input logic        if_fault,
  input logic        d_req,
  input logic        d_we,
  input logic        d_grant,
  input logic        d_fault,
  input logic        exc_valid,
  input logic [1:0]  exc_cause
);

  a_r8_if_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(if_grant && if_fault));
  a_r8_d_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(d_grant && d_fault));
  a_r8_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!if_req |-> !if_grant && !if_fault) and (!d_req |-> !d_grant && !d_fault));
  a_r2_pass: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> (if_grant == if_req) && (d_grant == d_req) && !if_fault && !d_fault);
  a_r10_fetch_first: assert property (@(posedge clk) disable iff (!rst_n)
    if_fault |=> exc_valid && exc_cause == 2'd1);
  a_r9_data_cause: assert property (@(posedge clk) disable iff (!rst_n)
    (d_fault && !if_fault) |=> exc_valid && exc_cause == ($past(d_we) ? 2'd3 : 2'd2));
  a_r9_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!if_fault && !d_fault) |=> !exc_valid && exc_cause == 2'd0);

endmodule

bind mprot_guard mprot_guard_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .enable   (enable),
  .if_req   (if_req),
  .if_grant (if_grant),
  .if_fault (if_fault),
  .d_req    (d_req),
  .d_we     (d_we),
  .d_grant  (d_grant),
  .d_fault  (d_fault),
  .exc_valid(exc_valid),
  .exc_cause(exc_cause)
);

// File: tb/sim_mprot_guard.sv
module sim_mprot_guard;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0, priv_super = 1'b0;
  logic        cfg_we = 1'b0, cfg_side = 1'b0;
  logic [2:0]  cfg_idx = '0;
  logic [1:0]  cfg_field = '0;
  logic [31:0] cfg_wdata = '0;
  logic        if_req = 1'b0, d_req = 1'b0, d_we = 1'b0;
  logic [31:0] if_addr = '0, d_addr = '0;
  logic        if_grant, if_fault, d_grant, d_fault, exc_valid;
  logic [1:0]  exc_cause;
  logic [31:0] exc_addr;

  always #10 clk = ~clk;

  mprot_guard u0 (
    .clk(clk), .rst_n(rst_n), .enable(enable), .priv_super(priv_super),
    .cfg_we(cfg_we), .cfg_side(cfg_side), .cfg_idx(cfg_idx),
    .cfg_field(cfg_field), .cfg_wdata(cfg_wdata),
    .if_req(if_req), .if_addr(if_addr), .if_grant(if_grant), .if_fault(if_fault),
    .d_req(d_req), .d_we(d_we), .d_addr(d_addr), .d_grant(d_grant), .d_fault(d_fault),
    .exc_valid(exc_valid), .exc_cause(exc_cause), .exc_addr(exc_addr)
  );

  int total = 0, bad = 0;
  logic        done = 1'b0;
  logic [31:0] m_lo [2][8];
  logic [31:0] m_hi [2][8];
  logic [5:0]  m_pm [2][8];
  logic        p_v = 1'b0;
  logic [1:0]  p_c = '0;
  logic [31:0] p_a = '0;

  // reference decision: first covering window decides, bits u r/w/x then s r/w/x
  function automatic logic ref_ok(int side, logic [31:0] a, logic sup, int kind);
    for (int r = 0; r < 8; r++)
      if (m_lo[side][r] <= a && a <= m_hi[side][r])
        return m_pm[side][r][(sup ? 3 : 0) + kind];
    return 1'b0;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_pend();
    chk("R9 exc_valid", 32'(exc_valid), 32'(p_v));
    chk("R9 exc_cause", 32'(exc_cause), p_v ? 32'(p_c) : 32'd0);
    if (p_v) chk("R9 exc_addr", exc_addr, p_a);
  endtask

  task automatic cfg(logic side, int idx, int fld, logic [31:0] data);
    @(negedge clk);
    check_pend();
    if_req = 0; d_req = 0;
    cfg_we = 1; cfg_side = side; cfg_idx = 3'(idx); cfg_field = 2'(fld); cfg_wdata = data;
    if (fld == 0) m_lo[side][idx] = data;
    else if (fld == 1) m_hi[side][idx] = data;
    else if (fld == 2) m_pm[side][idx] = data[5:0];
    p_v = 0;
  endtask

  task automatic region(logic side, int idx, logic [31:0] lo, logic [31:0] hi, logic [5:0] pm);
    cfg(side, idx, 0, lo);
    cfg(side, idx, 1, hi);
    cfg(side, idx, 2, 32'(pm));
  endtask

  task automatic access(string req, logic en, logic sup, logic ir, logic [31:0] ia,
                        logic dr, logic dw, logic [31:0] da);
    logic iok, dok, ef_i, ef_d;
    @(negedge clk);
    check_pend();
    cfg_we = 0;
    enable = en; priv_super = sup;
    if_req = ir; if_addr = ia; d_req = dr; d_we = dw; d_addr = da;
    #2;
    iok  = ref_ok(0, ia, sup, 2);
    dok  = ref_ok(1, da, sup, dw ? 1 : 0);
    ef_i = ir && en && !iok;
    ef_d = dr && en && !dok;
    chk({req, " if_grant"}, 32'(if_grant), 32'(ir && (!en || iok)));
    chk({req, " if_fault"}, 32'(if_fault), 32'(ef_i));
    chk({req, " d_grant"},  32'(d_grant),  32'(dr && (!en || dok)));
    chk({req, " d_fault"},  32'(d_fault),  32'(ef_d));
    p_v = ef_i || ef_d;
    p_c = ef_i ? 2'd1 : (dw ? 2'd3 : 2'd2);
    p_a = ef_i ? ia : da;
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    for (int s = 0; s < 2; s++)
      for (int r = 0; r < 8; r++) begin
        m_lo[s][r] = '1; m_hi[s][r] = '0; m_pm[s][r] = '0;
      end
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset state, everything faults when enabled
    @(negedge clk);
    chk("R1 exc_valid after reset", 32'(exc_valid), 32'd0);
    access("R1", 1, 1, 1, 32'h0, 1, 0, 32'h0);
    access("R1", 1, 0, 0, 32'h0, 1, 1, 32'hffff_ffff);
    // R2: disabled passes everything
    access("R2", 0, 0, 1, 32'h1234, 1, 1, 32'h55);
    // R3 / R11: inclusive bounds on window 2 of data table
    region(1, 2, 32'h100, 32'h1ff, 6'b011011);
    access("R3 lo", 1, 0, 0, 0, 1, 0, 32'h100);
    access("R3 hi", 1, 0, 0, 0, 1, 1, 32'h1ff);
    access("R3 above", 1, 0, 0, 0, 1, 0, 32'h200);
    access("R5 below", 1, 0, 0, 0, 1, 0, 32'h0ff);
    // R6: fetch table separate from data table
    access("R6 other table", 1, 1, 1, 32'h150, 0, 0, 0);
    region(0, 5, 32'h100, 32'h1ff, 6'b100000);
    access("R6 sup exec", 1, 1, 1, 32'h150, 0, 0, 0);
    access("R6 user exec", 1, 0, 1, 32'h150, 0, 0, 0);
    // R4: overlapping lower index wins (read-only over read/write)
    region(1, 0, 32'h180, 32'h18f, 6'b001001);
    access("R4 low idx", 1, 0, 0, 0, 1, 1, 32'h184);
    access("R4 low idx rd", 1, 1, 0, 0, 1, 0, 32'h184);
    access("R4 outside", 1, 1, 0, 0, 1, 1, 32'h190);
    // R7: write needs write bit, mode specific
    region(1, 3, 32'h400, 32'h4ff, 6'b010001);
    access("R7 user wr", 1, 0, 0, 0, 1, 1, 32'h410);
    access("R7 sup wr", 1, 1, 0, 0, 1, 1, 32'h410);
    access("R7 sup rd", 1, 1, 0, 0, 1, 0, 32'h410);
    // R10: both fault, fetch reported
    access("R10", 1, 0, 1, 32'h900, 1, 1, 32'h900);
    // R11: field 3 has no effect; empty window (R11 lo>hi) matches nothing
    cfg(1, 3, 3, 32'h0);
    access("R11 field3", 1, 1, 0, 0, 1, 1, 32'h410);
    region(1, 6, 32'h800, 32'h700, 6'b111111);
    access("R11 empty", 1, 1, 0, 0, 1, 0, 32'h780);
    // random phase
    for (int k = 0; k < 6; k++) begin
      logic [31:0] lo;
      lo = 32'($urandom % 4096);
      region(k[0], 32'($urandom % 8), lo, lo + 32'($urandom % 1024), 6'($urandom));
    end
    for (int k = 0; k < 400; k++)
      access("R3 R4 R5 R6 R7 random", 1'($urandom % 8 != 0), 1'($urandom),
             1'($urandom), 32'($urandom % 5120), 1'($urandom), 1'($urandom),
             32'($urandom % 5120));
    access("R8 idle", 1, 0, 0, 0, 0, 0, 0);
    @(negedge clk);
    check_pend();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule